// File: doc/BRIEF.md
# Prioritized Interrupt Entry Sequencer

This block performs the entry half of exception handling for an 8-bit processor core with a 16-bit address space. At every instruction boundary the core pulses `boundary_i`. The block then weighs four request sources in a fixed order: a latched hard-reset request, the non-maskable line, the fast maskable line and the normal maskable line. It picks at most one of them and runs that source's entry sequence. The sequence saves state on the system stack through a byte-wide write port, one byte per clock. It then fetches the handler address through a 16-bit read port and returns the new stack pointer, program counter, direct-page value and condition-code byte, together with the cost of the entry in processor cycles.

There are two frame depths. The non-maskable and normal maskable entries save the whole register file. The fast entry saves only the program counter and the condition codes. Bit 7 of the saved condition-code byte records which depth was used, so a later return can unwind the right number of bytes. The masks are not symmetric. The normal entry sets only its own mask bit, while the non-maskable and fast entries set both mask bits. Instruction execution and the return sequence are outside this block.

Top module: `intc_entry_seq`

## Requirements
- R1: After reset is released, the block is idle: `busy_o`, `done_o`, `wr_en_o` and `rd_en_o` are all low.
- R2: A request is evaluated only in a cycle where `boundary_i` is high and the block is idle. The order of precedence is pending hard reset, then non-maskable, then fast, then normal. `kind_o` reports the entry taken: 0 reset, 1 non-maskable, 2 fast, 3 normal.
- R3: A pulse on `rst_req_i` is latched and stays pending until its entry is taken, then it clears itself. The reset entry writes nothing to the stack. It sets condition-code bits 6 and 4, leaves all other bits unchanged, clears the direct page, leaves S unchanged, loads PC from 0xFFFE and reports a cost of 0.
- R4: The non-maskable entry saves the full frame with bit 7 set in the saved condition codes. The result has bits 7, 6 and 4 set. PC is loaded from 0xFFFC and the cost is 19.
- R5: The fast entry is taken only when condition-code bit 6 is clear. It saves only PC and then the condition codes, with bit 7 cleared in the saved byte. The result has bit 7 clear and bits 6 and 4 set. PC is loaded from 0xFFF6 and the cost is 10.
- R6: The normal entry is taken only when condition-code bit 4 is clear. It saves the full frame with bit 7 set. The result has bit 4 set and bit 6 unchanged. PC is loaded from 0xFFF8 and the cost is 19.
- R7: Every stack write first decrements S. The full frame pushes PC, U, Y, X, DP, B, A and then the condition codes, in that order. A 16-bit register goes low byte first, so its high byte lands at the lower address. The returned S is the entry S minus 12 for a full frame, or minus 3 for a fast frame.
- R8: The vector read is big-endian. `rd_data_i[15:8]` is the byte at the even address `rd_addr_o` and becomes the high byte of the new PC.
- R9: A fast request that is masked does not block an unmasked normal request at the same boundary.
- R10: The fast and normal lines are levels that acceptance does not clear. A line still held is taken again at a later boundary once its mask bit is clear.
- R11: A boundary with nothing takeable causes no stack write, no vector read and no `done_o`.
- R12: A `boundary_i` pulse while the block is busy is ignored and does not start a second entry.
- R13: The first stack write appears in the cycle after the accepting clock edge, and one byte is written per cycle. The vector read comes in the cycle after the last write, or in the first cycle for a reset. `done_o` is high for exactly one cycle after the read, and the results stay held until the next entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronized inside |
| boundary_i | input | 1 | Instruction-boundary strobe |
| rst_req_i | input | 1 | Hard-reset request pulse (latched) |
| nmi_i | input | 1 | Non-maskable request line |
| fast_irq_i | input | 1 | Fast maskable request line (short frame) |
| irq_i | input | 1 | Normal maskable request line (full frame) |
| pc_i | input | 16 | Current program counter |
| u_i | input | 16 | Current user stack pointer |
| y_i | input | 16 | Current Y index |
| x_i | input | 16 | Current X index |
| s_i | input | 16 | Current system stack pointer |
| dp_i | input | 8 | Current direct-page register |
| b_i | input | 8 | Current B accumulator |
| a_i | input | 8 | Current A accumulator |
| cc_i | input | 8 | Current condition codes (bit 7 frame depth, 6 fast mask, 4 normal mask) |
| wr_en_o | output | 1 | Stack byte write strobe |
| wr_addr_o | output | 16 | Stack write address |
| wr_data_o | output | 8 | Stack write byte |
| rd_en_o | output | 1 | Vector read strobe |
| rd_addr_o | output | 16 | Vector address (even) |
| rd_data_i | input | 16 | Vector word, valid in the same cycle as `rd_en_o` |
| busy_o | output | 1 | Entry sequence in progress |
| done_o | output | 1 | One-cycle completion strobe |
| kind_o | output | 2 | Entry taken (0 reset, 1 non-maskable, 2 fast, 3 normal) |
| pc_o | output | 16 | New program counter |
| s_o | output | 16 | New system stack pointer |
| dp_o | output | 8 | New direct-page register |
| cc_o | output | 8 | New condition codes |
| cycles_o | output | 5 | Processor cycles charged for the entry |

## Verification
The assertions assume that the vector port answers combinationally in the cycle `rd_en_o` is high. They also assume that `boundary_i` is driven as a short strobe rather than held between entries, since a held strobe restarts the block immediately after `done_o`. The stimulus uses a bench-side vector model that answers in the same cycle. It raises the boundary strobe for one cycle per entry, with one deliberate extra pulse in the middle of a sequence. It holds the request lines steady until completion and then drops them, so no entry runs that the stimulus did not intend.

// File: rtl/intc_entry_pkg.sv
package intc_entry_pkg;

  localparam int WORD_W      = 16;
  localparam int BYTE_W      = 8;
  localparam int FRAME_SLOTS = 12;
  localparam int SLOT_W      = $clog2(FRAME_SLOTS);

  // Condition-code bit positions that later code decodes
  localparam int CCB_FULL  = 7;
  localparam int CCB_FMASK = 6;
  localparam int CCB_IMASK = 4;

  localparam logic [WORD_W-1:0] TOP_ADDR = '1;
  localparam logic [WORD_W-1:0] VEC_RST  = TOP_ADDR - WORD_W'(1);
  localparam logic [WORD_W-1:0] VEC_NMI  = TOP_ADDR - WORD_W'(3);
  localparam logic [WORD_W-1:0] VEC_IRQ  = TOP_ADDR - WORD_W'(7);
  localparam logic [WORD_W-1:0] VEC_FAST = TOP_ADDR - WORD_W'(9);

  typedef enum logic [1:0] {
    ENT_RESET = 2'd0,
    ENT_NMI   = 2'd1,
    ENT_FAST  = 2'd2,
    ENT_IRQ   = 2'd3
  } entry_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PUSH = 2'd1,
    ST_VEC  = 2'd2
  } seq_st_e;

  function automatic logic [WORD_W-1:0] vector_of(entry_e k);
    case (k)
      ENT_RESET: return VEC_RST;
      ENT_NMI:   return VEC_NMI;
      ENT_FAST:  return VEC_FAST;
      default:   return VEC_IRQ;
    endcase
  endfunction

endpackage

// File: rtl/intc_prio_pick.sv
module intc_prio_pick
  import intc_entry_pkg::*;
(
  input  logic   rst_pend_i,
  input  logic   nmi_i,
  input  logic   fast_i,
  input  logic   irq_i,
  input  logic   fmask_i,
  input  logic   imask_i,
  output logic   take_o,
  output entry_e kind_o
);

  // Each tier is considered only when every higher tier is absent or masked
  always_comb begin
    take_o = 1'b1;
    kind_o = ENT_IRQ;
    if (rst_pend_i) begin
      kind_o = ENT_RESET;
    end else if (nmi_i) begin
      kind_o = ENT_NMI;
    end else if (fast_i && !fmask_i) begin
      kind_o = ENT_FAST;
    end else if (irq_i && !imask_i) begin
      kind_o = ENT_IRQ;
    end else begin
      take_o = 1'b0;
    end
  end

endmodule

// File: rtl/intc_frame_mux.sv
module intc_frame_mux
  import intc_entry_pkg::*;
(
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [WORD_W-1:0] pc_i,
  input  logic [WORD_W-1:0] u_i,
  input  logic [WORD_W-1:0] y_i,
  input  logic [WORD_W-1:0] x_i,
  input  logic [BYTE_W-1:0] dp_i,
  input  logic [BYTE_W-1:0] b_i,
  input  logic [BYTE_W-1:0] a_i,
  input  logic [BYTE_W-1:0] cc_i,
  output logic [BYTE_W-1:0] byte_o
);

  localparam int NWORDS    = 4;
  localparam int BYTES_PW  = WORD_W / BYTE_W;
  localparam int TBL_DEPTH = 1 << SLOT_W;

  logic [WORD_W-1:0] words [NWORDS];
  logic [BYTE_W-1:0] slots [TBL_DEPTH];

  assign words[0] = pc_i;
  assign words[1] = u_i;
  assign words[2] = y_i;
  assign words[3] = x_i;

  // Word registers occupy the first slots, low byte first
  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    for (genvar k = 0; k < BYTES_PW; k++) begin : g_byte
      assign slots[w*BYTES_PW + k] = words[w][k*BYTE_W +: BYTE_W];
    end
  end

  assign slots[NWORDS*BYTES_PW + 0] = dp_i;
  assign slots[NWORDS*BYTES_PW + 1] = b_i;
  assign slots[NWORDS*BYTES_PW + 2] = a_i;
  assign slots[NWORDS*BYTES_PW + 3] = cc_i;

  for (genvar p = FRAME_SLOTS; p < TBL_DEPTH; p++) begin : g_pad
    assign slots[p] = '0;
  end

  assign byte_o = slots[slot_i];

endmodule

// File: rtl/intc_entry_seq.sv
module intc_entry_seq
  import intc_entry_pkg::*;
#(
  parameter int NMI_COST  = 19,
  parameter int FAST_COST = 10,
  parameter int IRQ_COST  = 19,
  parameter int RST_COST  = 0,
  parameter int CYC_W     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boundary_i,
  input  logic              rst_req_i,
  input  logic              nmi_i,
  input  logic              fast_irq_i,
  input  logic              irq_i,
  input  logic [15:0]       pc_i,
  input  logic [15:0]       u_i,
  input  logic [15:0]       y_i,
  input  logic [15:0]       x_i,
  input  logic [15:0]       s_i,
  input  logic [7:0]        dp_i,
  input  logic [7:0]        b_i,
  input  logic [7:0]        a_i,
  input  logic [7:0]        cc_i,
  output logic              wr_en_o,
  output logic [15:0]       wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              rd_en_o,
  output logic [15:0]       rd_addr_o,
  input  logic [15:0]       rd_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [1:0]        kind_o,
  output logic [15:0]       pc_o,
  output logic [15:0]       s_o,
  output logic [7:0]        dp_o,
  output logic [7:0]        cc_o,
  output logic [CYC_W-1:0]  cycles_o
);

  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(FRAME_SLOTS - 1);
  localparam logic [SLOT_W-1:0] SLOT_PCHI = SLOT_W'(1);

  // ---------------- reset release synchronizer ----------------
  logic [1:0] rsync_q;
  logic       arst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign arst_n = rsync_q[1];

  // ---------------- state ----------------
  seq_st_e           st_q, st_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic              rpend_q, rpend_d;
  logic              done_q, done_d;
  logic [WORD_W-1:0] sp_q, sp_d;
  logic              sp_en;

  entry_e            kind_q;
  logic [WORD_W-1:0] pc_q, u_q, y_q, x_q;
  logic [BYTE_W-1:0] dp_q, b_q, a_q, ccs_q;

  entry_e            res_kind_q;
  logic [WORD_W-1:0] res_pc_q, res_s_q;
  logic [BYTE_W-1:0] res_dp_q, res_cc_q;
  logic [CYC_W-1:0]  res_cyc_q;

  // ---------------- selection ----------------
  logic   pick_take;
  entry_e pick_kind;
  logic   accept;
  logic [BYTE_W-1:0] cc_stk;

  intc_prio_pick u_pick (
    .rst_pend_i (rpend_q),
    .nmi_i      (nmi_i),
    .fast_i     (fast_irq_i),
    .irq_i      (irq_i),
    .fmask_i    (cc_i[CCB_FMASK]),
    .imask_i    (cc_i[CCB_IMASK]),
    .take_o     (pick_take),
    .kind_o     (pick_kind)
  );

  assign accept = boundary_i && (st_q == ST_IDLE) && pick_take;

  // Saved condition codes carry the frame depth in the top bit
  always_comb begin
    cc_stk = cc_i;
    case (pick_kind)
      ENT_FAST:  cc_stk[CCB_FULL] = 1'b0;
      ENT_RESET: cc_stk[CCB_FULL] = cc_i[CCB_FULL];
      default:   cc_stk[CCB_FULL] = 1'b1;
    endcase
  end

  // ---------------- frame byte selection ----------------
  intc_frame_mux u_frame (
    .slot_i (slot_q),
    .pc_i   (pc_q),
    .u_i    (u_q),
    .y_i    (y_q),
    .x_i    (x_q),
    .dp_i   (dp_q),
    .b_i    (b_q),
    .a_i    (a_q),
    .cc_i   (ccs_q),
    .byte_o (wr_data_o)
  );

  // ---------------- next-state logic ----------------
  always_comb begin
    st_d      = st_q;
    slot_d    = slot_q;
    sp_d      = sp_q;
    sp_en     = 1'b0;
    done_d    = 1'b0;
    wr_en_o   = 1'b0;
    rd_en_o   = 1'b0;
    wr_addr_o = sp_q - WORD_W'(1);
    rd_addr_o = vector_of(kind_q);
    rpend_d   = (rpend_q && !(accept && pick_kind == ENT_RESET)) || rst_req_i;
    case (st_q)
      ST_IDLE: begin
        if (accept) begin
          sp_d   = s_i;
          sp_en  = 1'b1;
          slot_d = '0;
          st_d   = (pick_kind == ENT_RESET) ? ST_VEC : ST_PUSH;
        end
      end
      ST_PUSH: begin
        wr_en_o = 1'b1;
        sp_d    = sp_q - WORD_W'(1);
        sp_en   = 1'b1;
        if (slot_q == SLOT_LAST) begin
          st_d = ST_VEC;
        end else if (kind_q == ENT_FAST && slot_q == SLOT_PCHI) begin
          slot_d = SLOT_LAST;
        end else begin
          slot_d = slot_q + SLOT_W'(1);
        end
      end
      ST_VEC: begin
        rd_en_o = 1'b1;
        done_d  = 1'b1;
        st_d    = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // ---------------- result computation ----------------
  logic [BYTE_W-1:0] cc_res;
  logic [BYTE_W-1:0] dp_res;
  logic [CYC_W-1:0]  cyc_res;

  always_comb begin
    cc_res            = ccs_q;
    cc_res[CCB_IMASK] = 1'b1;
    if (kind_q != ENT_IRQ) cc_res[CCB_FMASK] = 1'b1;
    dp_res = (kind_q == ENT_RESET) ? '0 : dp_q;
    case (kind_q)
      ENT_RESET: cyc_res = CYC_W'(RST_COST);
      ENT_NMI:   cyc_res = CYC_W'(NMI_COST);
      ENT_FAST:  cyc_res = CYC_W'(FAST_COST);
      default:   cyc_res = CYC_W'(IRQ_COST);
    endcase
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      st_q    <= ST_IDLE;
      slot_q  <= '0;
      rpend_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      slot_q  <= slot_d;
      rpend_q <= rpend_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk) begin
    if (sp_en) sp_q <= sp_d;
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      kind_q <= pick_kind;
      pc_q   <= pc_i;
      u_q    <= u_i;
      y_q    <= y_i;
      x_q    <= x_i;
      dp_q   <= dp_i;
      b_q    <= b_i;
      a_q    <= a_i;
      ccs_q  <= cc_stk;
    end
  end

  always_ff @(posedge clk) begin
    if (st_q == ST_VEC) begin
      res_kind_q <= kind_q;
      res_pc_q   <= rd_data_i;
      res_s_q    <= sp_q;
      res_dp_q   <= dp_res;
      res_cc_q   <= cc_res;
      res_cyc_q  <= cyc_res;
    end
  end

  assign busy_o   = (st_q != ST_IDLE);
  assign done_o   = done_q;
  assign kind_o   = res_kind_q;
  assign pc_o     = res_pc_q;
  assign s_o      = res_s_q;
  assign dp_o     = res_dp_q;
  assign cc_o     = res_cc_q;
  assign cycles_o = res_cyc_q;

endmodule

// File: rtl/intc_entry_chk.sv
module intc_entry_chk
  import intc_entry_pkg::*;
#(
  parameter int NMI_COST  = 19,
  parameter int FAST_COST = 10,
  parameter int IRQ_COST  = 19,
  parameter int CYC_W     = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en_o,
  input logic [15:0]       wr_addr_o,
  input logic              rd_en_o,
  input logic [15:0]       rd_addr_o,
  input logic              busy_o,
  input logic              done_o,
  input logic [1:0]        kind_o,
  input logic [7:0]        cc_o,
  input logic [CYC_W-1:0]  cycles_o
);

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!wr_en_o && !rd_en_o));

  assert_port_excl_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_o && rd_en_o));

  assert_push_descend_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && $past(wr_en_o)) |-> (wr_addr_o == $past(wr_addr_o) - 16'd1));

  assert_read_done_R13: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_o |=> done_o);

  assert_done_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_vec_even_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_o |-> !rd_addr_o[0]);

  assert_nmi_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && kind_o == ENT_NMI) |->
      (cc_o[CCB_FULL] && cc_o[CCB_FMASK] && cc_o[CCB_IMASK] && cycles_o == CYC_W'(NMI_COST)));

  assert_fast_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && kind_o == ENT_FAST) |->
      (!cc_o[CCB_FULL] && cc_o[CCB_FMASK] && cc_o[CCB_IMASK] && cycles_o == CYC_W'(FAST_COST)));

  assert_irq_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && kind_o == ENT_IRQ) |->
      (cc_o[CCB_FULL] && cc_o[CCB_IMASK] && cycles_o == CYC_W'(IRQ_COST)));

endmodule

bind intc_entry_seq intc_entry_chk #(
  .NMI_COST  (NMI_COST),
  .FAST_COST (FAST_COST),
  .IRQ_COST  (IRQ_COST),
  .CYC_W     (CYC_W)
) u_entry_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en_o   (wr_en_o),
  .wr_addr_o (wr_addr_o),
  .rd_en_o   (rd_en_o),
  .rd_addr_o (rd_addr_o),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .kind_o    (kind_o),
  .cc_o      (cc_o),
  .cycles_o  (cycles_o)
);

// File: tb/intc_entry_seq_tb.sv
`timescale 1ns/1ps
module intc_entry_seq_tb_top;

  localparam logic [15:0] PC0 = 16'hA1B2, U0 = 16'hC3D4, Y0 = 16'hE5F6, X0 = 16'h1728;
  localparam logic [15:0] S0  = 16'h8000;
  localparam logic [7:0]  DP0 = 8'h39, B0 = 8'h4A, A0 = 8'h5B;

  // {lines rst/nmi/fast/irq, cc_in, taken, kind, pushes, expected cc}
  localparam logic [26:0] CASES [10] = '{
    {4'b0100, 8'h00, 1'b1, 2'd1, 4'd12, 8'hD0},
    {4'b0010, 8'h00, 1'b1, 2'd2, 4'd3,  8'h50},
    {4'b0001, 8'h0F, 1'b1, 2'd3, 4'd12, 8'h9F},
    {4'b0001, 8'h4A, 1'b1, 2'd3, 4'd12, 8'hDA},
    {4'b0011, 8'h40, 1'b1, 2'd3, 4'd12, 8'hD0},
    {4'b0011, 8'h00, 1'b1, 2'd2, 4'd3,  8'h50},
    {4'b0111, 8'hFF, 1'b1, 2'd1, 4'd12, 8'hFF},
    {4'b0011, 8'h50, 1'b0, 2'd0, 4'd0,  8'h00},
    {4'b1111, 8'h21, 1'b1, 2'd0, 4'd0,  8'h71},
    {4'b0010, 8'h80, 1'b1, 2'd2, 4'd3,  8'h50}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic boundary, rst_req, nmi, fast, irq;
  logic [7:0]  cc_in;
  logic        wr_en, rd_en, busy, done;
  logic [15:0] wr_addr, rd_addr, rd_data, pc_out, s_out;
  logic [7:0]  wr_data, dp_out, cc_out;
  logic [1:0]  kind;
  logic [4:0]  cyc;

  always #2 clk = ~clk;

  function automatic logic [15:0] vec_word(input logic [15:0] a);
    return {a[7:0] ^ 8'h5A, a[7:0] + 8'h11};
  endfunction

  always_comb rd_data = vec_word(rd_addr);

  intc_entry_seq dut_i (
    .clk(clk), .rst_n(rst_n), .boundary_i(boundary), .rst_req_i(rst_req),
    .nmi_i(nmi), .fast_irq_i(fast), .irq_i(irq),
    .pc_i(PC0), .u_i(U0), .y_i(Y0), .x_i(X0), .s_i(S0),
    .dp_i(DP0), .b_i(B0), .a_i(A0), .cc_i(cc_in),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .rd_en_o(rd_en), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .busy_o(busy), .done_o(done), .kind_o(kind),
    .pc_o(pc_out), .s_o(s_out), .dp_o(dp_out), .cc_o(cc_out), .cycles_o(cyc)
  );

  int n_cmp = 0, n_bad = 0;
  bit finished = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  logic [15:0] log_a [16];
  logic [7:0]  log_d [16];
  int n_wr, rd_at, done_at;

  task automatic run_entry(input logic [3:0] lines, input logic [7:0] cc, input bit poke);
    @(negedge clk);
    if (lines[3]) begin
      rst_req = 1'b1;
      @(negedge clk);
      rst_req = 1'b0;
    end
    nmi = lines[2]; fast = lines[1]; irq = lines[0]; cc_in = cc;
    boundary = 1'b1;
    @(negedge clk);
    boundary = 1'b0;
    n_wr = 0; rd_at = -1; done_at = -1;
    for (int t = 1; t <= 24; t++) begin
      if (wr_en) begin
        if (n_wr < 16) begin
          log_a[n_wr] = wr_addr;
          log_d[n_wr] = wr_data;
        end
        n_wr++;
      end
      if (rd_en) rd_at = t;
      if (done) begin
        done_at = t;
        break;
      end
      boundary = (poke && t == 4);
      @(negedge clk);
    end
    boundary = 1'b0; nmi = 1'b0; fast = 1'b0; irq = 1'b0;
  endtask

  function automatic logic [7:0] exp_byte(input int slot, input logic [7:0] ccs);
    case (slot)
      0: return PC0[7:0];  1: return PC0[15:8];
      2: return U0[7:0];   3: return U0[15:8];
      4: return Y0[7:0];   5: return Y0[15:8];
      6: return X0[7:0];   7: return X0[15:8];
      8: return DP0;       9: return B0;
      10: return A0;
      default: return ccs;
    endcase
  endfunction

  function automatic logic [15:0] exp_vec(input logic [1:0] k);
    case (k)
      2'd0: return 16'hFFFE;
      2'd1: return 16'hFFFC;
      2'd2: return 16'hFFF6;
      default: return 16'hFFF8;
    endcase
  endfunction

  function automatic int exp_cost(input logic [1:0] k);
    case (k)
      2'd0: return 0;
      2'd2: return 10;
      default: return 19;
    endcase
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; boundary = 1'b0; rst_req = 1'b0;
    nmi = 1'b0; fast = 1'b0; irq = 1'b0; cc_in = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 idle after reset
    chk("R1 busy", 32'(busy), 0);
    chk("R1 done", 32'(done), 0);
    chk("R1 wr_en", 32'(wr_en), 0);
    chk("R1 rd_en", 32'(rd_en), 0);

    // Table walk: R2 precedence, R3..R9, R11, R13 timing
    for (int i = 0; i < 10; i++) begin
      logic [3:0] ln;
      logic [7:0] ci, ecc, ccs;
      logic       tk;
      logic [1:0] ek;
      int         np;
      ln = CASES[i][26:23]; ci = CASES[i][22:15]; tk = CASES[i][14];
      ek = CASES[i][13:12]; np = int'(CASES[i][11:8]); ecc = CASES[i][7:0];
      ccs = (ek == 2'd2) ? (ci & 8'h7F) : (ci | 8'h80);
      run_entry(ln, ci, 1'b0);
      chk("R2 taken", 32'(done_at > 0), 32'(tk));
      if (!tk) begin
        chk("R11 no writes", 32'(n_wr), 0);
        chk("R11 no read", 32'(rd_at), 32'hFFFFFFFF);
      end else begin
        chk("R2 kind", 32'(kind), 32'(ek));
        chk("R4 R5 R6 R3 flags", 32'(cc_out), 32'(ecc));
        chk("R8 pc from vector", 32'(pc_out), 32'(vec_word(exp_vec(ek))));
        chk("R7 new S", 32'(s_out), 32'(S0 - 16'(np)));
        chk("R3 dp", 32'(dp_out), 32'((ek == 2'd0) ? 8'h00 : DP0));
        chk("R4 R5 R6 cost", 32'(cyc), 32'(exp_cost(ek)));
        chk("R7 push count", 32'(n_wr), 32'(np));
        chk("R13 read cycle", 32'(rd_at), 32'(np + 1));
        chk("R13 done cycle", 32'(done_at), 32'(np + 2));
        for (int j = 0; j < np; j++) begin
          int slot;
          slot = (np == 3 && j == 2) ? 11 : j;
          chk("R7 push addr", 32'(log_a[j]), 32'(S0 - 16'(j + 1)));
          chk("R7 push data", 32'(log_d[j]), 32'(exp_byte(slot, ccs)));
        end
      end
    end

    // R3 reset request cleared by its own entry
    run_entry(4'b0000, 8'h00, 1'b0);
    chk("R3 reset self-clear", 32'(done_at > 0), 0);

    // R10 held normal line taken again once unmasked
    run_entry(4'b0001, 8'h00, 1'b0);
    chk("R10 first entry", 32'(kind), 32'd3);
    run_entry(4'b0001, 8'h00, 1'b0);
    chk("R10 second entry", 32'(done_at > 0), 1);
    chk("R10 second kind", 32'(kind), 32'd3);

    // R12 boundary during a sequence is ignored
    run_entry(4'b0100, 8'h00, 1'b1);
    chk("R12 writes", 32'(n_wr), 12);
    chk("R12 done cycle", 32'(done_at), 14);
    begin
      int extra;
      extra = 0;
      for (int t = 0; t < 20; t++) begin
        @(negedge clk);
        if (done || wr_en) extra++;
      end
      chk("R12 no restart", 32'(extra), 0);
    end
    chk("R13 result held", 32'(s_out), 32'(S0 - 16'd12));

    finish_run();
  end

endmodule